// File: doc/BRIEF.md
# Video-Priority SDRAM Access Arbiter

This block decides which requester may use a shared SDRAM controller next. There are four requesters: two display read engines (an LCD panel engine and a VGA engine), a periodic refresh request, and one already-arbitrated request from the main system bus. The two display engines always win over refresh, and refresh always wins over the main bus. Between the two display engines a control bit names a favoured engine. That engine wins a tie, but right after it has been served the other engine gets the next turn if it is waiting.

Grants are registered and one-hot. A grant stays held until its transaction ends. For display and main-bus grants, the end is a one-cycle done pulse from the SDRAM sequencer. A refresh grant releases itself once it has strobed the four external memory devices one after another, one per cycle, which keeps peak supply current down. The block also reports the burst length tied to the current grant: 16 words for a display read and 8 half-word accesses for the main bus. It flags a write only when the main bus owns the memory.

Top module: `sdram_access_arb`

## Requirements
- R1: While reset is held, and in the first cycle after reset releases with no request present, all grant outputs, `grant_write` and every refresh strobe are 0. A refresh request pulse seen during reset is not remembered.
- R2: Grants are one-hot: no more than one of `grant_lcd`, `grant_vga`, `grant_rfsh`, `grant_host` is high at any time. A new grant appears at the clock edge that follows an idle cycle in which a request is present.
- R3: When requests are present together in an idle cycle, a display engine is granted before refresh, and refresh is granted before the main bus.
- R4: When both display engines request in the same idle cycle and the favoured engine was not the last display engine served, the favoured engine is granted. `prefer_vga`=1 favours VGA and `prefer_vga`=0 favours LCD. After reset the favoured engine is treated as not yet served.
- R5: After the favoured display engine has been served, the other engine is granted next if it is requesting, even if the favoured engine is still requesting.
- R6: A display engine that requests alone is granted directly, and that grant counts as its turn for the alternation in R4 and R5.
- R7: A display or main-bus grant stays unchanged, even while higher-priority requests arrive, until `xfer_done` is seen high.
- R8: When `xfer_done` is high during a display or main-bus grant, all grants are low after the next clock edge. The next grant can appear one edge later.
- R9: A refresh grant lasts exactly four cycles. `rfsh_dev` goes 0001, 0010, 0100, 1000 (bit n strobes device n), one value per cycle. After that, the grant and all strobes drop without any done pulse.
- R10: A one-cycle refresh request that arrives while another grant is active is held pending and is granted once the block is idle and no display engine is requesting.
- R11: `grant_write` is high only during a main-bus grant, and then equals `host_write` as sampled in the arbitration cycle. It is low during every display grant, whatever `host_write` is.
- R12: `burst_beats` is 16 during a display grant, 8 during a main-bus grant, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcd_req | input | 1 | LCD display engine read request |
| vga_req | input | 1 | VGA display engine read request |
| rfsh_req | input | 1 | Refresh request (pulse or level) |
| host_req | input | 1 | Main-bus request, already arbitrated upstream |
| host_write | input | 1 | Main-bus request is a write |
| prefer_vga | input | 1 | Control bit: 1 favours VGA on a tie, 0 favours LCD |
| xfer_done | input | 1 | One-cycle end-of-transaction pulse from the SDRAM sequencer |
| grant_lcd | output | 1 | LCD engine owns the SDRAM |
| grant_vga | output | 1 | VGA engine owns the SDRAM |
| grant_rfsh | output | 1 | Refresh owns the SDRAM |
| grant_host | output | 1 | Main bus owns the SDRAM |
| grant_write | output | 1 | Current grant is a main-bus write |
| burst_beats | output | 5 | Burst length of the current grant |
| rfsh_dev | output | 4 | Per-device refresh strobes |

## Verification
The bench targets the tie between the two display engines under both settings of the favour bit. It also checks that a lone request uses up an engine's turn. A design that stored a fixed turn pointer, or that ignored lone grants, would grant the same engine twice in a row. It sends a short refresh pulse while a display burst is active. A design that dropped the pulse would let the main bus in first, and a design that let refresh preempt would cut the burst short. It also checks that the main-bus grant survives arriving display requests, that the write flag never goes with a display grant, and that the four device strobes walk in order and release after exactly four cycles.

// File: rtl/sarb_pkg.sv
package sarb_pkg;

    typedef enum logic [2:0] {
        OWN_NONE = 3'd0,
        OWN_LCD  = 3'd1,
        OWN_VGA  = 3'd2,
        OWN_RFSH = 3'd3,
        OWN_HOST = 3'd4
    } owner_e;

    typedef struct packed {
        owner_e owner;        // current holder of the SDRAM
        logic   wr;           // main-bus grant is a write
        logic   served_pref;  // last display grant went to the favoured engine
        logic   rfsh_pend;    // refresh request waiting for service
    } arb_state_t;

endpackage

// File: rtl/sarb_video_pick.sv
module sarb_video_pick (
    input  logic lcd_req,
    input  logic vga_req,
    input  logic prefer_vga,
    input  logic served_pref_q,
    output logic pick_valid,
    output logic pick_vga,
    output logic pick_pref
);
    logic pref_req;
    logic other_req;

    always_comb begin
        pref_req   = prefer_vga ? vga_req : lcd_req;
        other_req  = prefer_vga ? lcd_req : vga_req;
        pick_valid = lcd_req | vga_req;
        // On a tie, the favoured engine wins unless it had the last turn (R4, R5)
        if (pref_req && other_req) begin
            pick_pref = ~served_pref_q;
        end else begin
            pick_pref = pref_req;
        end
        pick_vga = pick_pref ? prefer_vga : ~prefer_vga;
    end
endmodule

// File: rtl/sarb_rfsh_stagger.sv
module sarb_rfsh_stagger #(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    output logic [NUM_DEV-1:0] dev,
    output logic               last
);
    localparam int CW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = active && (cnt_q == CW'(NUM_DEV - 1));
        dev   = active ? (NUM_DEV'(1) << cnt_q) : '0;
        cnt_d = '0;
        if (active && !last) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    a_r9_dev_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev));

    a_r9_dev_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> (dev == ($past(dev) << 1)));

    a_r9_dev_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (dev == '0));
endmodule

// File: rtl/sdram_access_arb.sv
module sdram_access_arb
    import sarb_pkg::*;
#(
    parameter int VID_BEATS  = 16,
    parameter int HOST_BEATS = 8,
    parameter int NUM_DEV    = 4,
    localparam int BEAT_W    = $clog2(VID_BEATS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lcd_req,
    input  logic               vga_req,
    input  logic               rfsh_req,
    input  logic               host_req,
    input  logic               host_write,
    input  logic               prefer_vga,
    input  logic               xfer_done,
    output logic               grant_lcd,
    output logic               grant_vga,
    output logic               grant_rfsh,
    output logic               grant_host,
    output logic               grant_write,
    output logic [BEAT_W-1:0]  burst_beats,
    output logic [NUM_DEV-1:0] rfsh_dev
);
    arb_state_t st_d, st_q;

    logic pick_valid, pick_vga, pick_pref;
    logic rfsh_last;
    logic rfsh_any;

    sarb_video_pick i_pick (
        .lcd_req       (lcd_req),
        .vga_req       (vga_req),
        .prefer_vga    (prefer_vga),
        .served_pref_q (st_q.served_pref),
        .pick_valid    (pick_valid),
        .pick_vga      (pick_vga),
        .pick_pref     (pick_pref)
    );

    sarb_rfsh_stagger #(.NUM_DEV(NUM_DEV)) i_stagger (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (grant_rfsh),
        .dev    (rfsh_dev),
        .last   (rfsh_last)
    );

    always_comb begin
        st_d           = st_q;
        rfsh_any       = st_q.rfsh_pend | rfsh_req;
        st_d.rfsh_pend = rfsh_any;
        case (st_q.owner)
            OWN_NONE: begin
                if (pick_valid) begin
                    st_d.owner       = pick_vga ? OWN_VGA : OWN_LCD;
                    st_d.wr          = 1'b0;
                    st_d.served_pref = pick_pref;
                end else if (rfsh_any) begin
                    st_d.owner     = OWN_RFSH;
                    st_d.wr        = 1'b0;
                    st_d.rfsh_pend = 1'b0;
                end else if (host_req) begin
                    st_d.owner = OWN_HOST;
                    st_d.wr    = host_write;
                end
            end
            OWN_LCD, OWN_VGA, OWN_HOST: begin
                if (xfer_done) begin
                    st_d.owner = OWN_NONE;
                    st_d.wr    = 1'b0;
                end
            end
            OWN_RFSH: begin
                if (rfsh_last) begin
                    st_d.owner = OWN_NONE;
                end
            end
            default: begin
                st_d.owner = OWN_NONE;
                st_d.wr    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, wr: 1'b0, served_pref: 1'b0, rfsh_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        grant_lcd   = (st_q.owner == OWN_LCD);
        grant_vga   = (st_q.owner == OWN_VGA);
        grant_rfsh  = (st_q.owner == OWN_RFSH);
        grant_host  = (st_q.owner == OWN_HOST);
        grant_write = st_q.wr;
        if (grant_lcd || grant_vga) begin
            burst_beats = BEAT_W'(VID_BEATS);
        end else if (grant_host) begin
            burst_beats = BEAT_W'(HOST_BEATS);
        end else begin
            burst_beats = '0;
        end
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_lcd, grant_vga, grant_rfsh, grant_host}));

    a_r2_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_lcd) || $rose(grant_vga) || $rose(grant_host) || $rose(grant_rfsh))
        |-> $past({grant_lcd, grant_vga, grant_rfsh, grant_host} == 4'b0000));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_lcd || grant_vga || grant_host) && !xfer_done)
        |=> $stable({grant_lcd, grant_vga, grant_host}));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_lcd || grant_vga || grant_host) && xfer_done)
        |=> ({grant_lcd, grant_vga, grant_rfsh, grant_host} == 4'b0000));

    a_r9_self_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_rfsh && rfsh_dev[NUM_DEV-1]) |=> !grant_rfsh);

    a_r11_write_host: assert property (@(posedge clk) disable iff (!rst_n)
        grant_write |-> grant_host);
endmodule

// File: tb/test_sdram_access_arb.sv
module test_sdram_access_arb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       lcd_req, vga_req, rfsh_req, host_req, host_write, prefer_vga, xfer_done;
    logic       grant_lcd, grant_vga, grant_rfsh, grant_host, grant_write;
    logic [4:0] burst_beats;
    logic [3:0] rfsh_dev;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sdram_access_arb i_sdram_access_arb (
        .clk(clk), .rst_n(rst_n),
        .lcd_req(lcd_req), .vga_req(vga_req), .rfsh_req(rfsh_req),
        .host_req(host_req), .host_write(host_write), .prefer_vga(prefer_vga),
        .xfer_done(xfer_done),
        .grant_lcd(grant_lcd), .grant_vga(grant_vga), .grant_rfsh(grant_rfsh),
        .grant_host(grant_host), .grant_write(grant_write),
        .burst_beats(burst_beats), .rfsh_dev(rfsh_dev)
    );

    // grant code: 1 = LCD, 2 = VGA, 4 = refresh, 8 = main bus
    function automatic logic [31:0] gcode();
        return {28'd0, grant_host, grant_rfsh, grant_vga, grant_lcd};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic pv);
        rst_n = 1'b0;
        lcd_req = 0; vga_req = 0; rfsh_req = 0; host_req = 0;
        host_write = 0; xfer_done = 0; prefer_vga = pv;
        step(); step();
        rst_n = 1'b1;
    endtask

    // done pulse; returns at the negedge where grants must be low
    task automatic finish_xfer(input string req);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        check(req, "grants after done", gcode(), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        lcd_req = 0; vga_req = 0; host_req = 0; host_write = 0;
        xfer_done = 0; prefer_vga = 0;
        rfsh_req = 1'b1;
        step();
        check("R1", "grants in reset", gcode(), 0);
        check("R1", "strobes in reset", {28'd0, rfsh_dev}, 0);
        rfsh_req = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check("R1", "grants after reset", gcode(), 0);
        check("R1", "write after reset", {31'd0, grant_write}, 0);
        step();
        check("R1", "refresh pulse from reset not kept", gcode(), 0);
    endtask

    task automatic t_priority();
        do_reset(1'b0);
        lcd_req = 1; rfsh_req = 1; host_req = 1;
        step();
        check("R3", "video over refresh and host", gcode(), 1);
        check("R12", "video beats", {27'd0, burst_beats}, 16);
        lcd_req = 0; rfsh_req = 0;
        finish_xfer("R8");
        step();
        check("R10", "latched refresh before host", gcode(), 4);
        step(); step(); step();
        check("R9", "last strobe", {28'd0, rfsh_dev}, 8);
        step();
        check("R9", "refresh self release", gcode(), 0);
        step();
        check("R3", "host last", gcode(), 8);
        check("R12", "host beats", {27'd0, burst_beats}, 8);
        host_req = 0;
        finish_xfer("R8");
        check("R12", "idle beats", {27'd0, burst_beats}, 0);
    endtask

    task automatic t_refresh();
        do_reset(1'b0);
        rfsh_req = 1'b1;
        step();
        rfsh_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R9", "refresh grant held", gcode(), 4);
            check("R9", "strobe walk", {28'd0, rfsh_dev}, 32'd1 << i);
            step();
        end
        check("R9", "grant dropped", gcode(), 0);
        check("R9", "strobes dropped", {28'd0, rfsh_dev}, 0);
    endtask

    task automatic t_bias();
        do_reset(1'b1);
        lcd_req = 1; vga_req = 1;
        step();
        check("R4", "tie favours VGA when prefer_vga=1", gcode(), 2);
        finish_xfer("R8");
        step();
        check("R5", "LCD turn after VGA", gcode(), 1);
        finish_xfer("R8");
        step();
        check("R5", "back to VGA", gcode(), 2);
        do_reset(1'b0);
        lcd_req = 1; vga_req = 1;
        step();
        check("R4", "tie favours LCD when prefer_vga=0", gcode(), 1);
        finish_xfer("R8");
        step();
        check("R5", "VGA turn after LCD", gcode(), 2);
    endtask

    task automatic t_single();
        do_reset(1'b1);
        vga_req = 1;
        step();
        check("R6", "lone VGA granted", gcode(), 2);
        finish_xfer("R8");
        lcd_req = 1;
        step();
        check("R6", "lone VGA used the turn", gcode(), 1);
        do_reset(1'b1);
        lcd_req = 1;
        step();
        check("R6", "lone LCD granted", gcode(), 1);
        finish_xfer("R8");
        vga_req = 1;
        step();
        check("R6", "favoured VGA after lone LCD", gcode(), 2);
    endtask

    task automatic t_hold();
        do_reset(1'b0);
        host_req = 1; host_write = 1;
        step();
        check("R11", "host write flag", {31'd0, grant_write}, 1);
        check("R3", "host when alone", gcode(), 8);
        vga_req = 1; rfsh_req = 1;
        step();
        rfsh_req = 0;
        for (int i = 0; i < 3; i++) begin
            check("R7", "host not preempted", gcode(), 8);
            step();
        end
        finish_xfer("R8");
        step();
        check("R7", "VGA after host", gcode(), 2);
        check("R11", "no write for video", {31'd0, grant_write}, 0);
        vga_req = 0; host_req = 0;
        finish_xfer("R8");
        step();
        check("R10", "refresh pulse kept across bursts", gcode(), 4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_priority();
        t_refresh();
        t_bias();
        t_single();
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule